// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block converts one configuration-space request into the short sequence of register-bus transfers that a host bridge expects. A request names a bus number, a device slot, a function, a register offset, an access width and, for writes, the data. The sequencer builds an address word for the bridge, writes it into the bridge's address register and reads it back. If the read-back differs from the word written, it writes the word again. Once the read-back matches, it makes the data access through the bridge's data window at an offset taken from the low bits of the register offset.

Requests that the bridge cannot serve are refused before any bus traffic. These are a device slot that has been configured to be skipped, and a low-numbered slot on the bridge's own bus when local (type 0) addressing is in use. A refused read returns all ones and a refused write is dropped. A parameter selects the bridge generation. The newest generation always uses the routed (type 1) encoding and carries the upper register-offset bits in the top nibble of the address word. A programmable limit bounds the read-back retries, and when it is reached the request ends with an error flag.

Top module: `pci_cfg_seq`

## Requirements
- R1: For GEN below 4 and a request bus equal to own_bus_i, the address word has bit `dev` set (one-hot), the function at bits [10:8], offset bits [7:2] at [7:2], and bits [1:0] cleared.
- R2: Otherwise the address word is routed: bits [31:24] zero, bus at [23:16], device at [15:11], function at [10:8], offset bits [7:2] at [7:2], bit 1 clear and bit 0 set.
- R3: With local addressing on the own bus, a device number below 11 is refused with no register-bus transfer.
- R4: When skip_en_i is high, a request whose device equals skip_dev_i is refused with no register-bus transfer. When skip_en_i is low, the check is off.
- R5: With GEN equal to 4 the routed word is always used, even on the own bus and for any device number, and offset bits [11:8] occupy address-word bits [31:28].
- R6: The address word is written to BASE_ADDR+ADDR_OFS and then read from the same address. A read-back that differs from the word causes a rewrite. The data access starts only after a matching read-back.
- R7: After retry_lim_i+1 mismatching read-backs, the request ends with err_o high, rdata_o all ones and no data access.
- R8: The data access goes to BASE_ADDR+DATA_OFS+offset[2:0]. Its size code is req_size_i (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), and on writes it carries req_wdata_i unchanged.
- R9: A refused read acknowledges with rdata_o all ones and err_o low. A refused write acknowledges with no transfer.
- R10: The default window offsets are 0x800000 for the address register and 0xC00000 for the data window. The address-register transfers use size code 2.
- R11: A request is taken when req_i is high and busy_o is low. busy_o stays high from the next cycle through the single cycle in which ack_o is high. req_i is ignored while busy_o is high.
- R12: Each register-bus transfer raises rb_req_o for exactly one cycle and completes in the first cycle, starting with that strobe cycle, in which rb_rdy_i is high. The sequencer holds its state until then.
- R13: A completed read returns the data-window value masked to the access width: low 8 bits, low 16 bits or all 32 bits, zero-extended. A completed write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_dev_i | input | 5 | Target device slot |
| req_fn_i | input | 3 | Target function |
| req_ofs_i | input | 12 | Register offset |
| req_size_i | input | 2 | Access width code |
| req_wdata_i | input | 32 | Write data |
| own_bus_i | input | 8 | Bus number of the bridge itself |
| skip_en_i | input | 1 | Enables the skipped-slot check |
| skip_dev_i | input | 5 | Slot to refuse |
| retry_lim_i | input | 8 | Extra address writes allowed |
| busy_o | output | 1 | Request in progress |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Retry limit reached (with ack_o) |
| rdata_o | output | 32 | Returned data |
| rb_req_o | output | 1 | Register-bus transfer strobe |
| rb_we_o | output | 1 | Register-bus write |
| rb_addr_o | output | 32 | Register-bus byte address |
| rb_size_o | output | 2 | Register-bus size code |
| rb_wdata_o | output | 32 | Register-bus write data |
| rb_rdy_i | input | 1 | Transfer complete |
| rb_rdata_i | input | 32 | Register-bus read data |

## Verification
A wrong captured address word or a miscounted retry shows up on the register bus in the same request: the address write carries a bad word, the write/read pairs come in the wrong number, or a data access is made without a matching read-back. A stuck or skipped state is visible on the next cycle as a strobe lasting longer than one cycle, a strobe while idle, or an acknowledge without busy. A wrong width mask or window offset is visible at the acknowledge of the request that caused it.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int DW         = 32;
  localparam int BUS_W      = 8;
  localparam int DEV_W      = 5;
  localparam int FN_W       = 3;
  localparam int OFS_W      = 12;
  localparam int LANE_W     = 3;
  localparam int MIN_T0_DEV = 11;

  localparam logic [1:0] SZ_B1 = 2'd0;
  localparam logic [1:0] SZ_B2 = 2'd1;
  localparam logic [1:0] SZ_B4 = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AWR,
    ST_ARD,
    ST_DAT,
    ST_ACK
  } seq_st_e;
endpackage

// File: rtl/pci_cfg_enc.sv
module pci_cfg_enc
  import pci_cfg_pkg::*;
#(
  parameter int GEN = 3
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [BUS_W-1:0] own_bus_i,
  input  logic             skip_en_i,
  input  logic [DEV_W-1:0] skip_dev_i,
  output logic [DW-1:0]    word_o,
  output logic             reject_o
);
  localparam bit LOCAL_OK = (GEN < 4);
  localparam bit EXT_OFS  = (GEN == 4);

  logic          use_t0;
  logic [DW-1:0] w_t0, w_t1;
  logic [3:0]    ext_bits;

  always_comb begin
    use_t0   = LOCAL_OK && (bus_i == own_bus_i);
    w_t0     = (DW'(1) << dev_i) | {21'd0, fn_i, 8'd0} | {24'd0, ofs_i[7:2], 2'b00};
    w_t1     = {8'd0, bus_i, dev_i, fn_i, ofs_i[7:2], 2'b01};
    ext_bits = EXT_OFS ? ofs_i[11:8] : 4'd0;
    word_o   = (use_t0 ? w_t0 : w_t1) | {ext_bits, 28'd0};
    reject_o = (skip_en_i && (dev_i == skip_dev_i)) ||
               (use_t0 && (32'(dev_i) < MIN_T0_DEV));
  end

  always_comb begin
    if (use_t0 && !reject_o)
      a_r1_onehot_t0: assert ($countones(word_o[31:11]) == 1);
    if (!use_t0)
      a_r2_t1_flag: assert (word_o[1:0] == 2'b01);
  end
endmodule

// File: rtl/pci_cfg_lane.sv
module pci_cfg_lane
  import pci_cfg_pkg::*;
#(
  parameter int             AW        = 32,
  parameter logic [AW-1:0]  DATA_BASE = '0
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     raw_i,
  output logic [AW-1:0]     data_addr_o,
  output logic [DW-1:0]     masked_o
);
  logic [DW-1:0] mask;

  always_comb begin
    data_addr_o = DATA_BASE + AW'(lane_i);
    unique case (size_i)
      SZ_B1:   mask = DW'(8'hFF);
      SZ_B2:   mask = DW'(16'hFFFF);
      default: mask = '1;
    endcase
    masked_o = raw_i & mask;
  end
endmodule

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            LIM_W     = 8,
  parameter logic [AW-1:0] AREG_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [LANE_W-1:0] req_lane_i,
  input  logic [LIM_W-1:0]  retry_lim_i,
  input  logic [DW-1:0]     enc_word_i,
  input  logic              enc_reject_i,
  output logic [LANE_W-1:0] lane_o,
  output logic [1:0]        size_o,
  input  logic [AW-1:0]     data_addr_i,
  input  logic [DW-1:0]     rd_masked_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rb_req_o,
  output logic              rb_we_o,
  output logic [AW-1:0]     rb_addr_o,
  output logic [1:0]        rb_size_o,
  output logic [DW-1:0]     rb_wdata_o,
  input  logic              rb_rdy_i,
  input  logic [DW-1:0]     rb_rdata_i
);
  seq_st_e           st_q;
  logic              issued_q, we_q, err_q;
  logic [1:0]        size_q;
  logic [LANE_W-1:0] lane_q;
  logic [DW-1:0]     wdata_q, word_q, rdata_q;
  logic [LIM_W-1:0]  lim_q, tries_q;
  logic              in_phase, xfer_done;

  assign in_phase  = (st_q == ST_AWR) || (st_q == ST_ARD) || (st_q == ST_DAT);
  assign xfer_done = in_phase && rb_rdy_i;
  assign lane_o    = lane_q;
  assign size_o    = size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      size_q   <= '0;
      lane_q   <= '0;
      wdata_q  <= '0;
      word_q   <= '0;
      rdata_q  <= '0;
      lim_q    <= '0;
      tries_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          we_q     <= req_we_i;
          size_q   <= req_size_i;
          lane_q   <= req_lane_i;
          wdata_q  <= req_wdata_i;
          word_q   <= enc_word_i;
          lim_q    <= retry_lim_i;
          tries_q  <= '0;
          issued_q <= 1'b0;
          err_q    <= 1'b0;
          if (enc_reject_i) begin
            rdata_q <= '1;
            st_q    <= ST_ACK;
          end else begin
            st_q    <= ST_AWR;
          end
        end
        ST_AWR: begin
          if (xfer_done) begin
            issued_q <= 1'b0;
            st_q     <= ST_ARD;
          end else issued_q <= 1'b1;
        end
        ST_ARD: begin
          if (xfer_done) begin
            issued_q <= 1'b0;
            if (rb_rdata_i == word_q) begin
              st_q <= ST_DAT;
            end else if (tries_q == lim_q) begin
              err_q   <= 1'b1;
              rdata_q <= '1;
              st_q    <= ST_ACK;
            end else begin
              tries_q <= tries_q + 1'b1;
              st_q    <= ST_AWR;
            end
          end else issued_q <= 1'b1;
        end
        ST_DAT: begin
          if (xfer_done) begin
            issued_q <= 1'b0;
            rdata_q  <= we_q ? '0 : rd_masked_i;
            st_q     <= ST_ACK;
          end else issued_q <= 1'b1;
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (st_q != ST_IDLE);
    ack_o      = (st_q == ST_ACK);
    err_o      = ack_o && err_q;
    rdata_o    = rdata_q;
    rb_req_o   = in_phase && !issued_q;
    rb_we_o    = (st_q == ST_AWR) || ((st_q == ST_DAT) && we_q);
    rb_addr_o  = (st_q == ST_DAT) ? data_addr_i : AREG_ADDR;
    rb_size_o  = (st_q == ST_DAT) ? size_q : SZ_B4;
    rb_wdata_o = (st_q == ST_DAT) ? wdata_q : word_q;
  end

  a_r12_strobe_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_req_o && !rb_rdy_i) |=> !rb_req_o);
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rb_req_o);
  a_r11_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> busy_o);
  a_r11_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  a_r11_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r7_err_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && (rdata_o == '1)));
  a_r7_tries_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tries_q <= lim_q));
  a_r6_match_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DAT) && ($past(st_q) != ST_DAT)) |->
      (($past(st_q) == ST_ARD) && ($past(rb_rdata_i) == word_q)));
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int            GEN       = 3,
  parameter int            AW        = 32,
  parameter int            LIM_W     = 8,
  parameter logic [AW-1:0] BASE_ADDR = 32'hF200_0000,
  parameter logic [AW-1:0] ADDR_OFS  = 32'h0080_0000,
  parameter logic [AW-1:0] DATA_OFS  = 32'h00C0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [BUS_W-1:0] req_bus_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic [FN_W-1:0]  req_fn_i,
  input  logic [OFS_W-1:0] req_ofs_i,
  input  logic [1:0]       req_size_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [BUS_W-1:0] own_bus_i,
  input  logic             skip_en_i,
  input  logic [DEV_W-1:0] skip_dev_i,
  input  logic [LIM_W-1:0] retry_lim_i,
  output logic             busy_o,
  output logic             ack_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rb_req_o,
  output logic             rb_we_o,
  output logic [AW-1:0]    rb_addr_o,
  output logic [1:0]       rb_size_o,
  output logic [DW-1:0]    rb_wdata_o,
  input  logic             rb_rdy_i,
  input  logic [DW-1:0]    rb_rdata_i
);
  localparam logic [AW-1:0] AREG_ADDR = BASE_ADDR + ADDR_OFS;
  localparam logic [AW-1:0] DWIN_ADDR = BASE_ADDR + DATA_OFS;

  logic [DW-1:0]     enc_word, rd_masked;
  logic              enc_reject;
  logic [LANE_W-1:0] lane;
  logic [1:0]        size;
  logic [AW-1:0]     data_addr;

  pci_cfg_enc #(.GEN(GEN)) u_enc (
    .bus_i      (req_bus_i),
    .dev_i      (req_dev_i),
    .fn_i       (req_fn_i),
    .ofs_i      (req_ofs_i),
    .own_bus_i  (own_bus_i),
    .skip_en_i  (skip_en_i),
    .skip_dev_i (skip_dev_i),
    .word_o     (enc_word),
    .reject_o   (enc_reject)
  );

  pci_cfg_lane #(.AW(AW), .DATA_BASE(DWIN_ADDR)) u_lane (
    .lane_i      (lane),
    .size_i      (size),
    .raw_i       (rb_rdata_i),
    .data_addr_o (data_addr),
    .masked_o    (rd_masked)
  );

  pci_cfg_ctrl #(.AW(AW), .LIM_W(LIM_W), .AREG_ADDR(AREG_ADDR)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .req_we_i     (req_we_i),
    .req_size_i   (req_size_i),
    .req_wdata_i  (req_wdata_i),
    .req_lane_i   (req_ofs_i[LANE_W-1:0]),
    .retry_lim_i  (retry_lim_i),
    .enc_word_i   (enc_word),
    .enc_reject_i (enc_reject),
    .lane_o       (lane),
    .size_o       (size),
    .data_addr_i  (data_addr),
    .rd_masked_i  (rd_masked),
    .busy_o       (busy_o),
    .ack_o        (ack_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o),
    .rb_req_o     (rb_req_o),
    .rb_we_o      (rb_we_o),
    .rb_addr_o    (rb_addr_o),
    .rb_size_o    (rb_size_o),
    .rb_wdata_o   (rb_wdata_o),
    .rb_rdy_i     (rb_rdy_i),
    .rb_rdata_i   (rb_rdata_i)
  );

  a_r10_areg_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_req_o && (rb_addr_o == AREG_ADDR)) |-> (rb_size_o == SZ_B4));
endmodule

// File: tb/sim_pci_cfg_seq.sv
module sim_cfg_slave #(
  parameter logic [31:0] AREG = 32'h0,
  parameter logic [31:0] DWIN = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  int          lat,
  input  int          bad,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic        rdy,
  output logic [31:0] rdata
);
  logic        pend;
  int          wait_cnt, bad_left, log_n;
  logic [31:0] areg;
  logic        log_we   [32];
  logic [31:0] log_addr [32];
  logic [31:0] log_data [32];
  logic [1:0]  log_size [32];

  assign rdy = (req && lat == 0) || (pend && wait_cnt == 0);
  always_comb begin
    if (addr == AREG) rdata = areg ^ ((bad_left > 0) ? 32'h0000_0100 : 32'h0);
    else              rdata = addr ^ 32'h5A5A_5A5A;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; wait_cnt <= 0; bad_left <= 0; log_n <= 0; areg <= '0;
    end else begin
      if (clr) begin log_n <= 0; bad_left <= bad; end
      if (req && lat != 0) begin pend <= 1'b1; wait_cnt <= lat - 1; end
      else if (pend) begin
        if (wait_cnt == 0) pend <= 1'b0; else wait_cnt <= wait_cnt - 1;
      end
      if (rdy) begin
        if (log_n < 32) begin
          log_we[log_n]   <= we;
          log_addr[log_n] <= addr;
          log_data[log_n] <= we ? wdata : rdata;
          log_size[log_n] <= size;
          log_n <= log_n + 1;
        end
        if (we && addr == AREG) areg <= wdata;
        if (!we && addr == AREG && bad_left > 0) bad_left <= bad_left - 1;
      end
    end
  end
endmodule

module sim_pci_cfg_seq;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hF200_0000;
  localparam logic [31:0] AREG = BASE + 32'h0080_0000;
  localparam logic [31:0] DWIN = BASE + 32'h00C0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        r_we = 0;
  logic [7:0]  r_bus = 0;
  logic [4:0]  r_dev = 0;
  logic [2:0]  r_fn = 0;
  logic [11:0] r_ofs = 0;
  logic [1:0]  r_size = 0;
  logic [31:0] r_wdata = 0;
  logic [7:0]  own_bus = 8'd0;
  logic        skip_en = 0;
  logic [4:0]  skip_dev = 0;
  logic [7:0]  lim = 0;
  logic [1:0]  req_v = 0;
  logic        s_clr = 0;
  int          s_lat = 0, s_bad = 0;

  logic [1:0]  busy, ack, err, rb_req, rb_we, rb_rdy;
  logic [31:0] rdata [2];
  logic [31:0] rb_addr [2];
  logic [31:0] rb_wdata [2];
  logic [31:0] rb_rdata [2];
  logic [1:0]  rb_size [2];

  pci_cfg_seq #(.GEN(3), .BASE_ADDR(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_v[0]), .req_we_i(r_we),
    .req_bus_i(r_bus), .req_dev_i(r_dev), .req_fn_i(r_fn), .req_ofs_i(r_ofs),
    .req_size_i(r_size), .req_wdata_i(r_wdata), .own_bus_i(own_bus),
    .skip_en_i(skip_en), .skip_dev_i(skip_dev), .retry_lim_i(lim),
    .busy_o(busy[0]), .ack_o(ack[0]), .err_o(err[0]), .rdata_o(rdata[0]),
    .rb_req_o(rb_req[0]), .rb_we_o(rb_we[0]), .rb_addr_o(rb_addr[0]),
    .rb_size_o(rb_size[0]), .rb_wdata_o(rb_wdata[0]), .rb_rdy_i(rb_rdy[0]),
    .rb_rdata_i(rb_rdata[0]));

  pci_cfg_seq #(.GEN(4), .BASE_ADDR(BASE)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_v[1]), .req_we_i(r_we),
    .req_bus_i(r_bus), .req_dev_i(r_dev), .req_fn_i(r_fn), .req_ofs_i(r_ofs),
    .req_size_i(r_size), .req_wdata_i(r_wdata), .own_bus_i(own_bus),
    .skip_en_i(skip_en), .skip_dev_i(skip_dev), .retry_lim_i(lim),
    .busy_o(busy[1]), .ack_o(ack[1]), .err_o(err[1]), .rdata_o(rdata[1]),
    .rb_req_o(rb_req[1]), .rb_we_o(rb_we[1]), .rb_addr_o(rb_addr[1]),
    .rb_size_o(rb_size[1]), .rb_wdata_o(rb_wdata[1]), .rb_rdy_i(rb_rdy[1]),
    .rb_rdata_i(rb_rdata[1]));

  sim_cfg_slave #(.AREG(AREG), .DWIN(DWIN)) s0 (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .lat(s_lat), .bad(s_bad),
    .req(rb_req[0]), .we(rb_we[0]), .addr(rb_addr[0]), .size(rb_size[0]),
    .wdata(rb_wdata[0]), .rdy(rb_rdy[0]), .rdata(rb_rdata[0]));

  sim_cfg_slave #(.AREG(AREG), .DWIN(DWIN)) s1 (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .lat(s_lat), .bad(s_bad),
    .req(rb_req[1]), .we(rb_we[1]), .addr(rb_addr[1]), .size(rb_size[1]),
    .wdata(rb_wdata[1]), .rdy(rb_rdy[1]), .rdata(rb_rdata[1]));

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // per-clock protocol model: strobe width, idle quiet, ack inside busy
  logic [1:0] pv_req = 0, pv_rdy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (pv_req[i] && !pv_rdy[i])
          chk(!rb_req[i], "R12", "strobe longer than one cycle", 32'(rb_req[i]), 32'd0);
        if (!busy[i] && rb_req[i])
          chk(1'b0, "R12", "strobe while idle", 32'(rb_req[i]), 32'd0);
        if (ack[i] && !busy[i])
          chk(1'b0, "R11", "ack without busy", 32'(busy[i]), 32'd1);
      end
    end
    pv_req <= rb_req;
    pv_rdy <= rb_rdy;
  end

  function automatic logic [31:0] model_word(int gen, int bus, int dev, int fn, int ofs);
    logic [31:0] w;
    if (gen < 4 && bus == int'(own_bus))
      w = (32'd1 << dev) | 32'(fn << 8) | 32'(ofs & 'hFC);
    else
      w = 32'(bus << 16) | 32'(dev << 11) | 32'(fn << 8) | 32'(ofs & 'hFC) | 32'd1;
    if (gen == 4) w = w | (32'((ofs >> 8) & 'hF) << 28);
    return w;
  endfunction

  task automatic get_log(input int which, input int idx, output logic lwe,
                         output logic [31:0] laddr, output logic [31:0] ldata,
                         output logic [1:0] lsize);
    if (which == 0) begin
      lwe = s0.log_we[idx]; laddr = s0.log_addr[idx];
      ldata = s0.log_data[idx]; lsize = s0.log_size[idx];
    end else begin
      lwe = s1.log_we[idx]; laddr = s1.log_addr[idx];
      ldata = s1.log_data[idx]; lsize = s1.log_size[idx];
    end
  endtask

  task automatic run_req(input int which, input bit we, input int bus, input int dev,
                         input int fn, input int ofs, input int size,
                         input logic [31:0] wd, input int lat, input int bad,
                         input int lm, input string rq, input bit intrude);
    int gen, pairs, n_exp, n_got, acks, extra;
    bit rej, fail;
    logic [31:0] word, dat_addr, mask, exp_rd, got_rd;
    logic got_err, lwe;
    logic [31:0] laddr, ldata;
    logic [1:0] lsize;
    gen = (which == 0) ? 3 : 4;
    word = model_word(gen, bus, dev, fn, ofs);
    rej = (skip_en && dev == int'(skip_dev)) ||
          (gen < 4 && bus == int'(own_bus) && dev < 11);
    fail = !rej && (bad > lm);
    pairs = rej ? 0 : (fail ? lm + 1 : bad + 1);
    n_exp = rej ? 0 : (fail ? 2 * pairs : 2 * pairs + 1);
    dat_addr = DWIN + 32'(ofs & 7);
    mask = (size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (rej || fail) exp_rd = 32'hFFFF_FFFF;
    else if (we)     exp_rd = 32'h0;
    else             exp_rd = (dat_addr ^ 32'h5A5A_5A5A) & mask;

    @(negedge clk);
    s_lat = lat; s_bad = bad; s_clr = 1'b1;
    @(negedge clk);
    s_clr = 1'b0;
    r_we = we; r_bus = 8'(bus); r_dev = 5'(dev); r_fn = 3'(fn); r_ofs = 12'(ofs);
    r_size = 2'(size); r_wdata = wd; lim = 8'(lm);
    req_v[which] = 1'b1;
    @(negedge clk);
    req_v[which] = 1'b0;
    acks = 0; got_rd = '0; got_err = 1'b0;
    for (int c = 0; c < 400 && acks == 0; c++) begin
      if (intrude && c == 1) begin
        r_dev = 5'(dev ^ 1); r_we = ~we; req_v[which] = 1'b1;
      end
      if (intrude && c == 2) req_v[which] = 1'b0;
      if (ack[which]) begin acks = 1; got_rd = rdata[which]; got_err = err[which]; end
      else @(negedge clk);
    end
    req_v[which] = 1'b0;
    chk(acks == 1, rq, "acknowledge seen", 32'(acks), 32'd1);
    chk(got_rd == exp_rd, rq, "returned data", got_rd, exp_rd);
    chk(got_err == fail, rq, "error flag", 32'(got_err), 32'(fail));
    extra = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (ack[which]) extra++;
    end
    chk(extra == 0 && !busy[which], "R11", "idle with no further ack", 32'(extra), 32'd0);
    n_got = (which == 0) ? s0.log_n : s1.log_n;
    chk(n_got == n_exp, rq, "register-bus transfer count", 32'(n_got), 32'(n_exp));
    if (n_got == n_exp) begin
      for (int k = 0; k < pairs; k++) begin
        get_log(which, 2 * k, lwe, laddr, ldata, lsize);
        chk(lwe && laddr == AREG && lsize == 2'd2, "R10", "address write target", laddr, AREG);
        chk(ldata == word, rq, "address word", ldata, word);
        get_log(which, 2 * k + 1, lwe, laddr, ldata, lsize);
        chk(!lwe && laddr == AREG, "R6", "read-back target", laddr, AREG);
      end
      if (!rej && !fail) begin
        get_log(which, 2 * pairs, lwe, laddr, ldata, lsize);
        chk(lwe == we && laddr == dat_addr, "R8", "data access address", laddr, dat_addr);
        chk(lsize == 2'(size), "R8", "data access size", 32'(lsize), 32'(size));
        if (we) chk(ldata == wd, "R8", "data write value", ldata, wd);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(!busy[i] && !ack[i] && !err[i], "R11", "reset state idle", 32'(busy[i]), 32'd0);
      chk(!rb_req[i], "R12", "reset state no strobe", 32'(rb_req[i]), 32'd0);
    end
    // R1: local word, 4-byte read
    run_req(0, 0, 0, 12, 3, 'h46, 2, 32'h0, 0, 0, 2, "R1", 0);
    // R2: routed word, byte write, latency 2
    run_req(0, 1, 5, 7, 1, 'h13, 0, 32'hDEAD_BEEF, 2, 0, 2, "R2", 0);
    // R3: low slot on own bus refused
    run_req(0, 0, 0, 10, 0, 'h00, 2, 32'h0, 0, 0, 2, "R3", 0);
    run_req(0, 1, 0, 3, 0, 'h10, 2, 32'h1234_5678, 0, 0, 2, "R3", 0);
    // R4 / R9: skip slot refused for read and write
    skip_en = 1'b1; skip_dev = 5'd14;
    run_req(0, 0, 0, 14, 2, 'h08, 2, 32'h0, 0, 0, 2, "R9", 0);
    run_req(0, 1, 4, 14, 2, 'h08, 2, 32'hCAFE_0001, 0, 0, 2, "R4", 0);
    run_req(1, 0, 0, 14, 0, 'h04, 2, 32'h0, 1, 0, 2, "R4", 0);
    skip_en = 1'b0;
    run_req(0, 0, 0, 14, 2, 'h08, 2, 32'h0, 1, 0, 2, "R4", 0);
    // R6: read-back mismatches within limit
    run_req(0, 0, 3, 20, 5, 'h2D, 1, 32'h0, 1, 2, 3, "R6", 0);
    run_req(0, 1, 0, 31, 7, 'hFF, 2, 32'h0BAD_F00D, 0, 3, 3, "R6", 0);
    // R7: limit exceeded
    run_req(0, 0, 0, 15, 0, 'h00, 2, 32'h0, 0, 5, 1, "R7", 0);
    run_req(1, 1, 9, 2, 1, 'h100, 2, 32'h5555_AAAA, 1, 1, 0, "R7", 0);
    // R13: width masking
    run_req(0, 0, 0, 11, 0, 'h0A, 1, 32'h0, 0, 0, 1, "R13", 0);
    run_req(0, 0, 2, 1, 4, 'h37, 0, 32'h0, 2, 0, 1, "R13", 0);
    // R5: generation 4 always routed with extended offset bits
    run_req(1, 0, 0, 3, 0, 'h2C4, 2, 32'h0, 0, 0, 2, "R5", 0);
    run_req(1, 1, 6, 17, 6, 'hFFB, 1, 32'h0000_BEEF, 2, 1, 2, "R5", 0);
    // R11: request during busy ignored
    run_req(0, 0, 1, 9, 2, 'h20, 2, 32'h0, 3, 0, 2, "R11", 1);
    // R12: zero-latency path on both
    run_req(1, 0, 2, 0, 0, 'h05, 0, 32'h0, 0, 0, 2, "R12", 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule